// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block holds two inter-processor interrupt kinds for every CPU of a cluster. The "other" kind is raised by one CPU at any set of CPUs. The "self" kind is raised by a CPU at itself. Each kind has a pending flag and a mask bit. When a CPU has a pending kind that is not masked, its request line to the interrupt event logic goes high.

All CPUs share one register bus, and every access carries the index of the CPU making it. A CPU reads an event word to learn which kind is waiting. That read masks the reported kind. Software then acknowledges the pending flag and clears the mask by hand. No kind can fire again until software has handled it.

Top module: `ipi_unit`

## Requirements
- R1: A read of the identity register (word address 0) returns the index of the accessing CPU, zero-extended. Read data appears one cycle after the read is presented and holds its value until the next read.
- R2: A write to the send register (address 2) sets the "other" pending flag of every CPU n whose data bit n is 1. Data bits at or above NUM_CPU, other than bit 31, are ignored. The flags change one clock after the write is accepted.
- R3: A write to the send register with data bit 31 set raises the "self" pending flag of the accessing CPU only, with the same latency as R2.
- R4: In the acknowledge, mask-set and mask-clear registers, bit 0 is the "other" kind and bit 31 is the "self" kind. Writing 1 to the acknowledge register (address 3) clears the matching pending flag of the accessing CPU and of no other CPU. Reading address 3 returns the pending flags in the same bit positions.
- R5: Address 4 sets mask bits when 1 is written, and address 5 clears them when 1 is written. Both act on the accessing CPU only. Reading either address returns that CPU's mask bits at bits 31 and 0.
- R6: Request output bit n is high exactly when CPU n has a pending kind whose mask is clear. It changes on the same clock edge as the state that drives it.
- R7: A read of the event register (address 1) returns 0x0004_0001 when "other" is pending and unmasked, and 0x0004_0002 when only "self" is. The value is type 4 in bits 23:16 and the number in bits 15:0. "Other" is reported first. The read returns 0 when nothing is deliverable.
- R8: An event read that reports a kind sets that kind's mask bit and leaves the pending flag unchanged. The mask stays set until a mask-clear write.
- R9: When a send lands on the same clock edge as an acknowledge of "other" by the target CPU, the pending flag remains set.
- R10: After reset every pending flag is clear, every mask bit is set, the request outputs are low and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (not together with bus_wr) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | NUM_CPU | Per-CPU interrupt request |

## Verification
Read data is due at the first sample point after the clock edge that takes the read. Acknowledge and mask writes change the request outputs at that same edge. A send changes them one edge later, because the send bitmap passes through a register stage.

The table-driven part of the bench idles one cycle after every access before it samples, so all three latencies have settled by then. The directed tests sample on exact cycles. They check the identity read on the first cycle after it. They check a send as low after one edge and high after two. They place an acknowledge on the edge where a send lands to exercise the collision rule.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_WHOAMI = 3'd0,
    RA_EVENT  = 3'd1,
    RA_SEND   = 3'd2,
    RA_ACK    = 3'd3,
    RA_MSET   = 3'd4,
    RA_MCLR   = 3'd5
  } reg_addr_e;

  localparam int BIT_OTHER = 0;
  localparam int BIT_SELF  = 31;

  localparam logic [7:0]  EVT_TYPE_IPI  = 8'd4;
  localparam logic [15:0] EVT_NUM_OTHER = 16'd1;
  localparam logic [15:0] EVT_NUM_SELF  = 16'd2;

  localparam logic [31:0] EVT_WORD_OTHER = {8'd0, EVT_TYPE_IPI, EVT_NUM_OTHER};
  localparam logic [31:0] EVT_WORD_SELF  = {8'd0, EVT_TYPE_IPI, EVT_NUM_SELF};
endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [CPU_W-1:0]  bus_cpu,
  output logic [NUM_CPU-1:0] ack_oth,
  output logic [NUM_CPU-1:0] ack_slf,
  output logic [NUM_CPU-1:0] mset_oth,
  output logic [NUM_CPU-1:0] mset_slf,
  output logic [NUM_CPU-1:0] mclr_oth,
  output logic [NUM_CPU-1:0] mclr_slf,
  output logic [NUM_CPU-1:0] evt_rd,
  output logic [NUM_CPU-1:0] send_oth_q,
  output logic [NUM_CPU-1:0] send_slf_q
);
  logic wr_send, wr_ack, wr_mset, wr_mclr, rd_evt;

  always_comb begin
    wr_send = bus_wr && (bus_addr == RA_SEND);
    wr_ack  = bus_wr && (bus_addr == RA_ACK);
    wr_mset = bus_wr && (bus_addr == RA_MSET);
    wr_mclr = bus_wr && (bus_addr == RA_MCLR);
    rd_evt  = bus_rd && (bus_addr == RA_EVENT);
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic sel;
    assign sel         = (bus_cpu == CPU_W'(c));
    assign ack_oth[c]  = wr_ack  && sel && bus_wdata[BIT_OTHER];
    assign ack_slf[c]  = wr_ack  && sel && bus_wdata[BIT_SELF];
    assign mset_oth[c] = wr_mset && sel && bus_wdata[BIT_OTHER];
    assign mset_slf[c] = wr_mset && sel && bus_wdata[BIT_SELF];
    assign mclr_oth[c] = wr_mclr && sel && bus_wdata[BIT_OTHER];
    assign mclr_slf[c] = wr_mclr && sel && bus_wdata[BIT_SELF];
    assign evt_rd[c]   = rd_evt  && sel;

    always_ff @(posedge clk) begin
      if (rst) begin
        send_oth_q[c] <= 1'b0;
        send_slf_q[c] <= 1'b0;
      end else begin
        send_oth_q[c] <= wr_send && bus_wdata[c];
        send_slf_q[c] <= wr_send && sel && bus_wdata[BIT_SELF];
      end
    end
  end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        send_oth,
  input  logic        send_slf,
  input  logic        ack_oth,
  input  logic        ack_slf,
  input  logic        mset_oth,
  input  logic        mset_slf,
  input  logic        mclr_oth,
  input  logic        mclr_slf,
  input  logic        evt_rd,
  output logic        pend_oth,
  output logic        pend_slf,
  output logic        mask_oth,
  output logic        mask_slf,
  output logic        req,
  output logic [31:0] evt_word
);
  logic take_oth, take_slf;
  logic pend_oth_n, pend_slf_n, mask_oth_n, mask_slf_n;

  always_comb begin
    take_oth = pend_oth && !mask_oth;
    take_slf = pend_slf && !mask_slf && !take_oth;

    if (take_oth)      evt_word = EVT_WORD_OTHER;
    else if (take_slf) evt_word = EVT_WORD_SELF;
    else               evt_word = '0;

    // a landing send wins over a same-edge acknowledge
    pend_oth_n = (pend_oth && !ack_oth) || send_oth;
    pend_slf_n = (pend_slf && !ack_slf) || send_slf;
    mask_oth_n = (mask_oth || mset_oth || (evt_rd && take_oth)) && !mclr_oth;
    mask_slf_n = (mask_slf || mset_slf || (evt_rd && take_slf)) && !mclr_slf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_oth <= 1'b0;
      pend_slf <= 1'b0;
      mask_oth <= 1'b1;
      mask_slf <= 1'b1;
      req      <= 1'b0;
    end else begin
      pend_oth <= pend_oth_n;
      pend_slf <= pend_slf_n;
      mask_oth <= mask_oth_n;
      mask_slf <= mask_slf_n;
      req      <= (pend_oth_n && !mask_oth_n) || (pend_slf_n && !mask_slf_n);
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [CPU_W-1:0]   bus_cpu,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] irq_req
);
  logic [NUM_CPU-1:0] ack_oth, ack_slf, mset_oth, mset_slf, mclr_oth, mclr_slf;
  logic [NUM_CPU-1:0] evt_rd, send_oth_q, send_slf_q;
  logic [NUM_CPU-1:0] pend_oth, pend_slf, mask_oth, mask_slf;
  logic [NUM_CPU-1:0][31:0] evt_words;

  ipi_bus_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_cpu    (bus_cpu),
    .ack_oth    (ack_oth),
    .ack_slf    (ack_slf),
    .mset_oth   (mset_oth),
    .mset_slf   (mset_slf),
    .mclr_oth   (mclr_oth),
    .mclr_slf   (mclr_slf),
    .evt_rd     (evt_rd),
    .send_oth_q (send_oth_q),
    .send_slf_q (send_slf_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_slot
    ipi_cpu_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .send_oth (send_oth_q[c]),
      .send_slf (send_slf_q[c]),
      .ack_oth  (ack_oth[c]),
      .ack_slf  (ack_slf[c]),
      .mset_oth (mset_oth[c]),
      .mset_slf (mset_slf[c]),
      .mclr_oth (mclr_oth[c]),
      .mclr_slf (mclr_slf[c]),
      .evt_rd   (evt_rd[c]),
      .pend_oth (pend_oth[c]),
      .pend_slf (pend_slf[c]),
      .mask_oth (mask_oth[c]),
      .mask_slf (mask_slf[c]),
      .req      (irq_req[c]),
      .evt_word (evt_words[c])
    );
  end

  logic        cpu_ok;
  logic [31:0] rd_next;

  always_comb begin
    cpu_ok  = (int'(bus_cpu) < NUM_CPU);
    rd_next = '0;
    unique case (bus_addr)
      RA_WHOAMI: rd_next = 32'(bus_cpu);
      RA_EVENT:  if (cpu_ok) rd_next = evt_words[bus_cpu];
      RA_ACK:    if (cpu_ok) rd_next = {pend_slf[bus_cpu], 30'd0, pend_oth[bus_cpu]};
      RA_MSET,
      RA_MCLR:   if (cpu_ok) rd_next = {mask_slf[bus_cpu], 30'd0, mask_oth[bus_cpu]};
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [REG_AW-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [CPU_W-1:0]   bus_cpu,
  input logic [31:0]        bus_rdata,
  input logic [NUM_CPU-1:0] irq_req,
  input logic [NUM_CPU-1:0] pend_oth,
  input logic [NUM_CPU-1:0] pend_slf,
  input logic [NUM_CPU-1:0] mask_oth,
  input logic [NUM_CPU-1:0] mask_slf
);
  logic [NUM_CPU-1:0] last_send;
  always_ff @(posedge clk) begin
    if (rst) last_send <= '0;
    else     last_send <= (bus_wr && bus_addr == RA_SEND) ? bus_wdata[NUM_CPU-1:0] : '0;
  end

  logic ack_o, evt_r, who_r, mclr_w;
  assign ack_o  = bus_wr && bus_addr == RA_ACK && bus_wdata[BIT_OTHER];
  assign evt_r  = bus_rd && bus_addr == RA_EVENT;
  assign who_r  = bus_rd && bus_addr == RA_WHOAMI;
  assign mclr_w = bus_wr && bus_addr == RA_MCLR;

  assert_whoami_R1: assert property (@(posedge clk) disable iff (rst)
    who_r |=> bus_rdata == 32'($past(bus_cpu)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !last_send[bus_cpu]) |=> !pend_oth[$past(bus_cpu)]);

  assert_collision_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_o && last_send[bus_cpu]) |=> pend_oth[$past(bus_cpu)]);

  assert_event_other_first_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_r && pend_oth[bus_cpu] && !mask_oth[bus_cpu]) |=> bus_rdata == EVT_WORD_OTHER);

  assert_event_masks_R8: assert property (@(posedge clk) disable iff (rst)
    evt_r |=> ((bus_rdata != EVT_WORD_OTHER || mask_oth[$past(bus_cpu)]) &&
               (bus_rdata != EVT_WORD_SELF  || mask_slf[$past(bus_cpu)])));

  assert_mask_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(mclr_w) |-> ((($past(mask_oth) & ~mask_oth) == '0) &&
                        (($past(mask_slf) & ~mask_slf) == '0)));

  assert_reset_clean_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pend_oth == '0 && pend_slf == '0 && &mask_oth && &mask_slf &&
                    irq_req == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_req
    assert_req_state_R6: assert property (@(posedge clk) disable iff (rst)
      irq_req[c] == ((pend_oth[c] && !mask_oth[c]) || (pend_slf[c] && !mask_slf[c])));
  end
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_cpu   (bus_cpu),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req),
  .pend_oth  (pend_oth),
  .pend_slf  (pend_slf),
  .mask_oth  (mask_oth),
  .mask_slf  (mask_slf)
);

// File: tb/ipi_unit_bench.sv
module ipi_unit_bench;
  localparam int NUM_CPU = 4;
  localparam int CPU_W   = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [2:0]         bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [CPU_W-1:0]   bus_cpu = '0;
  logic [31:0]        bus_rdata;
  logic [NUM_CPU-1:0] irq_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ipi_unit #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_ipi_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  localparam logic [2:0] A_WHO = 3'd0, A_EVT = 3'd1, A_SEND = 3'd2, A_ACK = 3'd3,
                         A_MSET = 3'd4, A_MCLR = 3'd5;

  typedef struct packed {
    logic        rd;
    logic [2:0]  addr;
    logic [1:0]  cpu;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, A_MCLR, 2'd0, 32'h8000_0001, 4'b0000},
    '{1'b0, A_SEND, 2'd0, 32'h0000_0006, 4'b0000},
    '{1'b1, A_ACK,  2'd1, 32'h0000_0001, 4'b0000},
    '{1'b0, A_MCLR, 2'd1, 32'h0000_0001, 4'b0010},
    '{1'b0, A_SEND, 2'd2, 32'h8000_0001, 4'b0011},
    '{1'b1, A_EVT,  2'd0, 32'h0004_0001, 4'b0010},
    '{1'b1, A_EVT,  2'd0, 32'h0000_0000, 4'b0010},
    '{1'b0, A_ACK,  2'd0, 32'h0000_0001, 4'b0010},
    '{1'b0, A_MCLR, 2'd0, 32'h0000_0001, 4'b0010},
    '{1'b0, A_MCLR, 2'd2, 32'h8000_0001, 4'b0110},
    '{1'b1, A_EVT,  2'd2, 32'h0004_0001, 4'b0110},
    '{1'b1, A_EVT,  2'd2, 32'h0004_0002, 4'b0010},
    '{1'b1, A_MSET, 2'd2, 32'h8000_0001, 4'b0010},
    '{1'b1, A_ACK,  2'd2, 32'h8000_0001, 4'b0010},
    '{1'b0, A_ACK,  2'd2, 32'h8000_0001, 4'b0010},
    '{1'b1, A_ACK,  2'd2, 32'h0000_0000, 4'b0010},
    '{1'b1, A_WHO,  2'd3, 32'h0000_0003, 4'b0010},
    '{1'b0, A_SEND, 2'd3, 32'h0000_00F8, 4'b0010},
    '{1'b0, A_MCLR, 2'd3, 32'h0000_0001, 4'b1010},
    '{1'b0, A_ACK,  2'd1, 32'h8000_0000, 4'b1010},
    '{1'b1, A_MSET, 2'd0, 32'h0000_0000, 4'b1010}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bus_op(input logic rd, input logic [2:0] a, input logic [1:0] c,
                        input logic [31:0] d);
    bus_rd = rd; bus_wr = !rd; bus_addr = a; bus_cpu = c; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 irq_req", 32'(irq_req), 32'h0);
    check("R10 rdata", bus_rdata, 32'h0);
    bus_op(1'b1, A_MSET, 2'd1, '0);
    check("R10 masks set", bus_rdata, 32'h8000_0001);
    bus_op(1'b1, A_ACK, 2'd1, '0);
    check("R10 pending clear", bus_rdata, 32'h0);
    bus_op(1'b1, A_EVT, 2'd0, '0);
    check("R7 empty event", bus_rdata, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R1
    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].rd, VECS[i].addr, VECS[i].cpu, VECS[i].data);
      @(negedge clk);
      check($sformatf("R6 vec%0d irq_req", i), 32'(irq_req), 32'(VECS[i].req));
      if (VECS[i].rd)
        check($sformatf("R7 R8 R1 R4 R5 vec%0d rdata", i), bus_rdata, VECS[i].data);
    end

    // R1: identity due on the first cycle after the read
    bus_op(1'b1, A_WHO, 2'd2, '0);
    check("R1 whoami timing", bus_rdata, 32'd2);

    // R2: send lands one edge later (cpu0 unmasked, idle)
    bus_op(1'b0, A_SEND, 2'd1, 32'h1);
    check("R2 not yet", 32'(irq_req[0]), 32'h0);
    @(negedge clk);
    check("R2 landed", 32'(irq_req[0]), 32'h1);

    // R4: clear it
    bus_op(1'b0, A_ACK, 2'd0, 32'h1);
    check("R4 ack clears", 32'(irq_req[0]), 32'h0);

    // R9: ack on the edge the send lands
    bus_op(1'b0, A_SEND, 2'd1, 32'h1);
    bus_op(1'b0, A_ACK, 2'd0, 32'h1);
    check("R9 collision irq_req", 32'(irq_req[0]), 32'h1);
    bus_op(1'b1, A_ACK, 2'd0, '0);
    check("R9 collision pending", bus_rdata, 32'h1);

    // R3: self raised on own CPU only, still masked at cpu1
    bus_op(1'b0, A_SEND, 2'd1, 32'h8000_0000);
    @(negedge clk);
    bus_op(1'b1, A_ACK, 2'd1, '0);
    check("R3 self pending", bus_rdata, 32'h8000_0001);
    bus_op(1'b1, A_ACK, 2'd3, '0);
    check("R3 other cpu untouched", bus_rdata, 32'h0000_0001);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule